// File: doc/BRIEF.md
# Color-Index Palette Resolver

This block turns color-index texels into 32-bit RGBA texels. A texture memory of 4 KB keeps indexed texel data in its lower 2 KB half. The palette tables sit in the upper half, which is built as four banks of 256 sixteen-bit entries. Every bank holds the same table contents, so each of four texel lanes can read its own entry in the same cycle.

Each request carries four 8-bit indices, the tile's 4-bit palette number, a size select and a table-format bit. With small (4-bit) indices, the palette number sits above the low nibble of the index, so the sixteen palettes of sixteen entries each begin on 16-entry boundaries. With wide (8-bit) indices, the index addresses all 256 entries and the palette number plays no part. Each fetched entry is expanded to 8 bits per channel according to the format bit: either red/green/blue 5-5-5 with 1-bit alpha, or intensity/alpha 8-8.

A single write port loads one table word into all four banks at once. Several small tables can sit at any word offset inside the 256 entries.

Top module: `ci_palette_lookup`

## Requirements
- R1: While reset is asserted, and after it is released until a request is accepted, `out_valid` is 0.
- R2: A request accepted with `in_valid` high in cycle N produces `out_valid` high with all four texels in cycle N+1. No request means no valid result.
- R3: When `ci_wide` = 0, lane k looks up entry {`pal_num`, `in_idx[8k+3:8k]`}. The upper nibble of that lane's index has no effect.
- R4: When `ci_wide` = 1, lane k looks up entry `in_idx[8k+7:8k]`, and `pal_num` has no effect.
- R5: With `wr_en` = 1, `wr_data` is stored at entry `wr_addr` (0 to 255) in every bank. Any lane that later reads that entry returns it.
- R6: When `ia_mode` = 0, an entry holds R in [15:11], G in [10:6], B in [5:1] and A in [0]. Each 5-bit channel x becomes {x, x[4:2]}. A becomes 8'hFF when the bit is 1 and 8'h00 when it is 0.
- R7: When `ia_mode` = 1, an entry holds I in [15:8] and A in [7:0]. The output has R = G = B = I and A as stored.
- R8: A write and a lookup of the same entry in the same cycle return the entry's old value. The new value is seen from the next cycle.
- R9: Lane k's texel is placed at `out_texel[32k+31:32k]` as {R[31:24], G[23:16], B[15:8], A[7:0]}. The four lanes resolve independently, and lanes that address the same entry give the same texel.
- R10: The format bit is captured together with the request. Changing `ia_mode` in the cycle after the request does not change that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Lookup request for four lanes |
| in_idx | input | 32 | Four texel indices, lane k in bits [8k+7:8k] |
| pal_num | input | 4 | Tile palette number, used with 4-bit indices |
| ci_wide | input | 1 | 1 = 8-bit indices, 0 = 4-bit indices |
| ia_mode | input | 1 | Table format: 1 = intensity/alpha 8-8, 0 = RGBA 5-5-5-1 |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table entry written in all banks |
| wr_data | input | 16 | Table entry value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_texel | output | 128 | Four expanded 32-bit texels |

## Verification
A table write and a lookup can fall in the same cycle. The bench provokes this by raising `wr_en` and `in_valid` together, with the written address matching the entry that some lanes resolve to, both through a wide index and through a palette-plus-nibble index. It expects the pre-write contents in that result and the new word in the next lookup of the same entry. Back-to-back requests with alternating format bits likewise place a mode change in the cycle where the earlier result is still being formed. Each result must match the format captured with its own request.

// File: rtl/ci_palette_lookup.sv
module ci_palette_lookup #(
  parameter int LANES = 4,
  parameter int IDX_W = 8,
  parameter int PAL_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*IDX_W-1:0] in_idx,
  input  logic [PAL_W-1:0]      pal_num,
  input  logic                  ci_wide,
  input  logic                  ia_mode,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_addr,
  input  logic [15:0]           wr_data,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   out_texel
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LO_W  = IDX_W - PAL_W;

  logic             ia_q;
  logic             chk_ok;
  logic [IDX_W-1:0] lane_addr [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      chk_ok    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      chk_ok    <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (in_valid) ia_q <= ia_mode;

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
    out_valid == $past(in_valid));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] raw;
    logic [15:0]      bank [DEPTH];
    logic [15:0]      ent_q;
    logic [4:0]       r5, g5, b5;
    logic [31:0]      tex;

    assign raw          = in_idx[g*IDX_W +: IDX_W];
    assign lane_addr[g] = ci_wide ? raw : {pal_num, raw[LO_W-1:0]};

    always_ff @(posedge clk) begin
      if (wr_en) bank[wr_addr] <= wr_data;
      if (in_valid) ent_q <= bank[lane_addr[g]];
    end

    assign r5  = ent_q[15:11];
    assign g5  = ent_q[10:6];
    assign b5  = ent_q[5:1];
    assign tex = ia_q ? {ent_q[15:8], ent_q[15:8], ent_q[15:8], ent_q[7:0]}
                      : {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2], {8{ent_q[0]}}};
    assign out_texel[g*32 +: 32] = tex;

    assert_ia_gray_R7: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      out_valid && $past(ia_mode) |->
        (out_texel[g*32+24 +: 8] == out_texel[g*32+16 +: 8]) &&
        (out_texel[g*32+16 +: 8] == out_texel[g*32+8 +: 8]));

    assert_rgba_expand_R6: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      out_valid && !$past(ia_mode) |->
        ((out_texel[g*32 +: 8] == 8'h00) || (out_texel[g*32 +: 8] == 8'hFF)) &&
        (out_texel[g*32+24 +: 3] == out_texel[g*32+29 +: 3]));

    assert_lane_match_R9: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      out_valid && $past(lane_addr[g] == lane_addr[0]) |->
        out_texel[g*32 +: 32] == out_texel[31:0]);
  end
endmodule

// File: tb/tb_ci_palette_lookup.sv
module tb_ci_palette_lookup;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_idx = '0;
  logic [3:0]   pal_num = '0;
  logic         ci_wide = 1'b0;
  logic         ia_mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         out_valid;
  logic [127:0] out_texel;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [15:0]  model [256];
  logic [127:0] expq [$];
  string        tagq [$];
  int           cycq [$];

  ci_palette_lookup dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] expand(input logic [15:0] e, input logic ia);
    logic [4:0] r, g, b;
    r = e[15:11]; g = e[10:6]; b = e[5:1];
    if (ia) return {e[15:8], e[15:8], e[15:8], e[7:0]};
    return {r, r[4:2], g, g[4:2], b, b[4:2], (e[0] ? 8'hFF : 8'h00)};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic [31:0] idx, input logic [3:0] pal,
                       input logic wide, input logic ia, input logic wr,
                       input logic [7:0] wa, input logic [15:0] wd, input string tag);
    logic [127:0] exp;
    @(negedge clk);
    in_valid = rd; in_idx = idx; pal_num = pal; ci_wide = wide; ia_mode = ia;
    wr_en = wr; wr_addr = wa; wr_data = wd;
    if (rd) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a;
        a = wide ? idx[8*k +: 8] : {pal, idx[8*k +: 4]};
        exp[32*k +: 32] = expand(model[a], ia);
      end
      expq.push_back(exp); tagq.push_back(tag); cycq.push_back(cyc);
    end
    if (wr) model[wa] = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, ~ia_mode, 1'b0, '0, '0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check("R2 unexpected valid", {127'b0, out_valid}, 128'b0);
      end else begin
        logic [127:0] e;
        string t;
        int c;
        e = expq.pop_front(); t = tagq.pop_front(); c = cycq.pop_front();
        check("R2 latency", 128'(cyc), 128'(c + 1));
        check(t, out_texel, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {127'b0, out_valid}, 128'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {127'b0, out_valid}, 128'b0);

    for (int i = 0; i < 256; i++)
      drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 8'(i), 16'(i * 16'h9E37 ^ 16'h5A5B), "");

    drive(1'b1, 32'hFF_80_01_00, 4'h3, 1'b1, 1'b0, 1'b0, '0, '0, "R4 R6 R9 wide rgba");
    drive(1'b1, 32'h12_34_56_78, 4'h9, 1'b1, 1'b0, 1'b0, '0, '0, "R4 R9 wide distinct");
    drive(1'b1, 32'h12_34_56_78, 4'hE, 1'b1, 1'b0, 1'b0, '0, '0, "R4 palette ignored");
    idle(2);
    drive(1'b1, 32'hA3_03_F3_03, 4'h0, 1'b0, 1'b0, 1'b0, '0, '0, "R3 pal0 high nibble ignored");
    drive(1'b1, 32'h0F_1E_2D_3C, 4'hF, 1'b0, 1'b0, 1'b0, '0, '0, "R3 pal15");
    drive(1'b1, 32'hC5_B6_A7_98, 4'h7, 1'b0, 1'b1, 1'b0, '0, '0, "R3 R7 pal7 ia");
    drive(1'b1, 32'h11_22_33_44, 4'h0, 1'b1, 1'b1, 1'b0, '0, '0, "R7 R10 ia after ia");
    drive(1'b1, 32'h11_22_33_44, 4'h0, 1'b1, 1'b0, 1'b0, '0, '0, "R10 rgba after ia");
    drive(1'b1, 32'h11_22_33_44, 4'h0, 1'b1, 1'b1, 1'b0, '0, '0, "R10 ia after rgba");
    idle(1);

    drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 8'd40, 16'hF83F, "");
    drive(1'b1, 32'h28_28_28_28, 4'h0, 1'b1, 1'b0, 1'b0, '0, '0, "R5 all banks wide");
    drive(1'b1, 32'hF8_08_E8_08, 4'h2, 1'b0, 1'b1, 1'b0, '0, '0, "R5 all banks palette");
    drive(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 8'd41, 16'h0000, "");
    drive(1'b1, 32'h29_28_29_28, 4'h0, 1'b1, 1'b0, 1'b0, '0, '0, "R6 alpha zero R9");

    drive(1'b1, 32'h4D_4D_00_4D, 4'h0, 1'b1, 1'b0, 1'b1, 8'd77, 16'h07C1, "R8 collision old");
    drive(1'b1, 32'h4D_4D_00_4D, 4'h0, 1'b1, 1'b0, 1'b0, '0, '0, "R8 new next cycle");
    drive(1'b1, 32'hDD_0D_4D_FD, 4'h4, 1'b0, 1'b1, 1'b1, 8'd77, 16'hABCD, "R8 collision palette");
    drive(1'b1, 32'h0D_0D_0D_0D, 4'h4, 1'b0, 1'b1, 1'b0, '0, '0, "R8 R5 new palette");
    idle(4);

    if (expq.size() != 0)
      check("R2 results missing", 128'(expq.size()), 128'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule